// File: doc/BRIEF.md
# Frame Interval Meter

This block measures how far apart the frames of an incoming digital audio stream arrive. It counts a fast reference clock, and a frame strobe from the upstream decoder marks each frame. Each time a frame strobe arrives, the number of reference cycles since the previous strobe is divided by 32 and stored in an interval field. The field therefore holds reference cycles per 1/32 of a frame, and the sample rate equals the reference frequency divided by 32 times the field. The reference must run faster than 768 times the sample rate, so a valid reading is never below 24.

The block combines the decoder's lock indication with its own detection of a missing signal to form an unlock flag. The interval field reads as zero while that flag is set. A bad-format indication from the decoder and a low-frequency flag are also reported. All flags and the field sit in a single 32-bit status word. Two single-cycle event outputs mark gaining and losing lock, and interrupt logic downstream can use them.

Top module: `frm_rate_meter`

## Requirements
- R1: After reset the status word is 0x0000_0009: the unlock flag (bit 0) and the no-signal flag (bit 3) are set, and every other bit is zero. Both event outputs are low.
- R2: Each strobe that has an earlier valid strobe before it loads the interval field (status bits starting at 16, FIELD_W bits wide, 12 by default) with floor(P/32). P is the number of reference cycles between the two strobes. The new value is visible one cycle after the strobe.
- R3: The first strobe after reset or after a no-signal timeout leaves the field at zero. It only starts the next measurement.
- R4: When floor(P/32) exceeds the field's range, the field becomes all ones and the low-frequency flag (bit 2) is set. A later measurement that fits clears bit 2.
- R5: If no strobe arrives for 32·2^FIELD_W reference cycles after the last one, then on exactly that cycle bits 3 and 0 are set, the stored field is cleared and bit 2 is cleared. One cycle earlier, bit 3 is still clear. The next strobe clears bit 3.
- R6: The unlock flag becomes set one cycle after the lock input is low, or whenever no-signal is set. It is clear only when lock is high and no-signal is clear.
- R7: While the unlock flag is set, the field reads zero. The stored measurement is kept and reappears when the flag clears.
- R8: `locked_evt_o` pulses for one cycle when the unlock flag goes from 1 to 0. `loss_evt_o` pulses for one cycle when it goes from 0 to 1. The two are never high together.
- R9: The bad-format flag (bit 1) follows `fmt_err_i` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb_i | input | 1 | One-cycle pulse per received frame |
| lock_i | input | 1 | Decoder lock indication |
| fmt_err_i | input | 1 | Decoder bad-format indication |
| status_o | output | 32 | Status word: bit 0 unlock, bit 1 bad format, bit 2 low frequency, bit 3 no signal, interval field from bit 16 |
| locked_evt_o | output | 1 | Lock-gained event pulse |
| loss_evt_o | output | 1 | Lock-lost event pulse |

## Verification
The hardest corners to reach are the two edges of the period counter. One is a strobe that arrives on exactly the last cycle before the timeout, which must produce a saturated reading rather than a no-signal condition. The other is the cycle on which the timeout fires. To keep these windows short, the bench builds the block with an 8-bit field, so both edges lie 8192 cycles after a strobe. It places strobes with cycle-exact waits and samples once on the cycle before the timeout and once on the timeout cycle itself.

// File: rtl/frm_rate_pkg.sv
package frm_rate_pkg;
    localparam int STAT_W      = 32;
    localparam int BIT_UNLOCK  = 0;
    localparam int BIT_BADFMT  = 1;
    localparam int BIT_LOWFREQ = 2;
    localparam int BIT_NOSIG   = 3;
    localparam int FIELD_LSB   = 16;
    localparam int FRAC_SH     = 5;   // 1/32 of a frame
endpackage

// File: rtl/frm_period_cnt.sv
module frm_period_cnt #(
    parameter int CNT_W = 18,
    parameter int LIMIT = 131072
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    output logic [CNT_W-1:0] period_o,
    output logic             meas_o,
    output logic             timeout_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             tmo_d;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    always_comb begin
        cnt_d = cnt_q;
        tmo_d = 1'b0;
        if (stb_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            tmo_d = 1'b1;            // hold at the limit
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign period_o  = cnt_q + 1'b1;
    assign meas_o    = stb_i;
    assign timeout_o = tmo_d;
endmodule

// File: rtl/frm_interval_scale.sv
module frm_interval_scale #(
    parameter int CNT_W   = 18,
    parameter int FIELD_W = 12
) (
    input  logic [CNT_W-1:0]   period_i,
    output logic [FIELD_W-1:0] field_o,
    output logic               sat_o
);
    import frm_rate_pkg::*;

    localparam logic [CNT_W-1:0] MAXQ = CNT_W'((2 ** FIELD_W) - 1);

    logic [CNT_W-1:0] quot;

    always_comb begin
        quot = period_i >> FRAC_SH;
        if (quot > MAXQ) begin
            sat_o   = 1'b1;
            field_o = '1;
        end else begin
            sat_o   = 1'b0;
            field_o = quot[FIELD_W-1:0];
        end
    end
endmodule

// File: rtl/frm_rate_meter.sv
module frm_rate_meter #(
    parameter int FIELD_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_stb_i,
    input  logic        lock_i,
    input  logic        fmt_err_i,
    output logic [31:0] status_o,
    output logic        locked_evt_o,
    output logic        loss_evt_o
);
    import frm_rate_pkg::*;

    localparam int CNT_W = FIELD_W + FRAC_SH + 1;
    localparam int LIMIT = 2 ** (FIELD_W + FRAC_SH);

    typedef struct packed {
        logic               armed;
        logic [FIELD_W-1:0] field;
        logic               lowf;
        logic               nosig;
        logic               unlock;
        logic               badf;
        logic               lk_evt;
        logic               ls_evt;
    } state_t;

    state_t s_d, s_q;

    logic [CNT_W-1:0]   period;
    logic               meas, tmo;
    logic [FIELD_W-1:0] scaled;
    logic               sat;

    frm_period_cnt #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_i     (frame_stb_i),
        .period_o  (period),
        .meas_o    (meas),
        .timeout_o (tmo)
    );

    frm_interval_scale #(.CNT_W(CNT_W), .FIELD_W(FIELD_W)) u_scale (
        .period_i (period),
        .field_o  (scaled),
        .sat_o    (sat)
    );

    always_comb begin
        s_d        = s_q;
        s_d.badf   = fmt_err_i;
        if (meas) begin
            if (s_q.armed) begin
                s_d.field = scaled;
                s_d.lowf  = sat;
            end
            s_d.armed = 1'b1;
            s_d.nosig = 1'b0;
        end else if (tmo) begin
            s_d.armed = 1'b0;
            s_d.field = '0;
            s_d.lowf  = 1'b0;
            s_d.nosig = 1'b1;
        end
        s_d.unlock = !lock_i || s_d.nosig;
        s_d.lk_evt = s_q.unlock && !s_d.unlock;
        s_d.ls_evt = !s_q.unlock && s_d.unlock;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.unlock <= 1'b1;
            s_q.nosig  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        status_o              = '0;
        status_o[BIT_UNLOCK]  = s_q.unlock;
        status_o[BIT_BADFMT]  = s_q.badf;
        status_o[BIT_LOWFREQ] = s_q.lowf;
        status_o[BIT_NOSIG]   = s_q.nosig;
        status_o[FIELD_LSB +: FIELD_W] = s_q.unlock ? '0 : s_q.field;
    end

    assign locked_evt_o = s_q.lk_evt;
    assign loss_evt_o   = s_q.ls_evt;
endmodule

// File: rtl/frm_rate_meter_chk.sv
module frm_rate_meter_chk #(
    parameter int FIELD_W = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        lock_i,
    input logic [31:0] status_o,
    input logic        locked_evt_o,
    input logic        loss_evt_o
);
    logic [FIELD_W-1:0] fld;
    assign fld = status_o[16 +: FIELD_W];

    assert_unlock_on_nolock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(lock_i) |-> status_o[0]);
    assert_nosig_unlocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[3] |-> status_o[0]);
    assert_field_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] |-> (fld == '0));
    assert_events_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({locked_evt_o, loss_evt_o}));
    assert_loss_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        loss_evt_o |-> (status_o[0] && !$past(status_o[0])));
    assert_locked_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        locked_evt_o |-> (!status_o[0] && $past(status_o[0])));
    assert_lowfreq_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[2] && !status_o[0]) |-> (fld == '1));
endmodule

bind frm_rate_meter frm_rate_meter_chk #(.FIELD_W(FIELD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock_i       (lock_i),
    .status_o     (status_o),
    .locked_evt_o (locked_evt_o),
    .loss_evt_o   (loss_evt_o)
);

// File: tb/frm_rate_meter_tb.sv
`timescale 1ns/1ps
module frm_rate_meter_tb;
    localparam int FW  = 8;
    localparam int TMO = 32 * (2 ** FW);   // 8192

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stb = 1'b0;
    logic        lock = 1'b0;
    logic        fmt = 1'b0;
    logic [31:0] status;
    logic        lk_evt, ls_evt;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    frm_rate_meter #(.FIELD_W(FW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_stb_i  (stb),
        .lock_i       (lock),
        .fmt_err_i    (fmt),
        .status_o     (status),
        .locked_evt_o (lk_evt),
        .loss_evt_o   (ls_evt)
    );

    function automatic logic [31:0] word(input int fld, input logic nosig,
                                         input logic lowf, input logic badf,
                                         input logic unl);
        logic [31:0] w;
        w = 32'(fld) << 16;
        w[0] = unl; w[1] = badf; w[2] = lowf; w[3] = nosig;
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pulse();
        stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
    endtask

    task automatic period(input int p);
        repeat (p - 1) @(negedge clk);
        pulse();
    endtask

    task automatic t_reset();
        chk("R1 status", status, 32'h9);
        chk("R1 events", {30'd0, lk_evt, ls_evt}, 32'd0);
    endtask

    task automatic t_first_lock();
        lock = 1'b1;
        @(negedge clk);
        chk("R6 nosig keeps unlock", status, word(0, 1, 0, 0, 1));
        pulse();
        chk("R3 first strobe", status, 32'h0);
        chk("R8 locked pulse", {31'd0, lk_evt}, 32'd1);
    endtask

    task automatic t_measure();
        period(768);
        chk("R2 768", status, word(24, 0, 0, 0, 0));
        chk("R8 pulse ended", {31'd0, lk_evt}, 32'd0);
        period(1000);
        chk("R2 1000", status, word(31, 0, 0, 0, 0));
        period(800);
        chk("R2 800", status, word(25, 0, 0, 0, 0));
    endtask

    task automatic t_lock_toggle();
        lock = 1'b0;
        @(negedge clk);
        chk("R7 gated", status, word(0, 0, 0, 0, 1));
        chk("R8 loss pulse", {30'd0, lk_evt, ls_evt}, 32'd1);
        @(negedge clk);
        chk("R8 loss ends", {30'd0, lk_evt, ls_evt}, 32'd0);
        lock = 1'b1;
        @(negedge clk);
        chk("R7 restored", status, word(25, 0, 0, 0, 0));
        chk("R8 relock pulse", {30'd0, lk_evt, ls_evt}, 32'd2);
    endtask

    task automatic t_badfmt();
        fmt = 1'b1;
        @(negedge clk);
        chk("R9 set", status, word(25, 0, 0, 1, 0));
        fmt = 1'b0;
        @(negedge clk);
        chk("R9 clear", status, word(25, 0, 0, 0, 0));
    endtask

    task automatic t_saturate();
        pulse();
        period(TMO - 1);
        chk("R4 max fits", status, word(255, 0, 0, 0, 0));
        period(TMO);
        chk("R4 saturated", status, word(255, 0, 1, 0, 0));
        period(768);
        chk("R4 cleared", status, word(24, 0, 0, 0, 0));
    endtask

    task automatic t_timeout();
        repeat (TMO - 1) @(negedge clk);
        chk("R5 before limit", status, word(24, 0, 0, 0, 0));
        @(negedge clk);
        chk("R5 timeout", status, word(0, 1, 0, 0, 1));
        chk("R8 loss on timeout", {30'd0, lk_evt, ls_evt}, 32'd1);
        pulse();
        chk("R3 after timeout", status, 32'h0);
        period(1600);
        chk("R2 1600", status, word(50, 0, 0, 0, 0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_lock();
        t_measure();
        t_lock_toggle();
        t_badfmt();
        t_saturate();
        t_timeout();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule